// File: doc/BRIEF.md
# Prioritized Memory Chip-Select Decoder

This block maps a 16-bit processor address onto a single chip select. The candidates are four main flash sectors, four secondary (boot) flash sectors, one SRAM select, one I/O window and one peripheral I/O window. Each candidate is described by a programmable window, stored as an inclusive base and limit address plus an enable bit. The SRAM select is the OR of two such windows.

When windows overlap, a fixed three-tier priority picks the winner. The SRAM, I/O and peripheral windows form the top tier. The boot sectors come next, and the main sectors are lowest. For example, if main sector 0 spans 8000h-BFFFh, boot sector 0 spans 8000h-9FFFh and the SRAM spans 8000h-87FFh, then the SRAM owns 8000h-87FFh, boot sector 0 owns 8800h-9FFFh, and main sector 0 keeps A000h-BFFFh.

Two problems in the configuration are reported. One is two windows of the same tier that overlap. The other is a flash window wider than its physical sector. The selects follow the address combinationally. Windows are loaded one at a time through a write port that is sampled on the clock.

Top module: `memsel_decoder`

## Requirements
- R1: A synchronous active-low reset clears every window enable. While in reset and after it, all selects are low, no_hit is high, and both error flags are low.
- R2: A write with cfg_we high loads {cfg_en, cfg_base, cfg_limit} into window cfg_idx on the rising clock edge. The window indices are:
  - 0-3: main sectors 0-3
  - 4-7: boot sectors 0-3
  - 8-9: SRAM terms 0-1
  - 10: I/O window
  - 11: peripheral I/O window

  A write to an index of 12 or above changes nothing.
- R3: An enabled window matches when base <= addr <= limit, with both bounds included. A disabled window never matches.
- R4: When windows of different tiers overlap, the winner is chosen in this order:
  - an SRAM, I/O or peripheral hit wins over any flash hit;
  - otherwise a boot sector hit wins over a main sector hit.
- R5: ram_sel is high when the address matches either SRAM term.
- R6: At most one of main_sel, boot_sel, ram_sel, io_sel and pio_sel is high. no_hit is high exactly when none of them is high.
- R7: ovl_err is high when two enabled, well-formed windows of the same tier overlap.
  - ovl_a and ovl_b report the lowest such pair: the smallest first index, then the smallest second index.
  - The two SRAM terms may overlap each other without error.
  - Overlaps between different tiers never raise the flag.
- R8: size_err is high when an enabled flash window has limit < base, or covers more addresses than its sector. A main sector holds 16384 addresses and a boot sector holds 8192. size_win reports the lowest such window index.
- R9: With the example mapping from the description, the decoder gives:
  - 8000h-87FFh: SRAM
  - 8800h-9FFFh: boot sector 0
  - A000h-BFFFh: main sector 0
  - addresses outside 8000h-BFFFh: no_hit
- R10: When a misconfiguration lets two windows of one tier match the same address, the lowest index wins. The selects and the error flags are updated in the same cycle.
- R11: The selects respond to an address change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | 4 | Index of the window to write |
| cfg_en | input | 1 | Enable bit to store |
| cfg_base | input | 16 | Inclusive lower bound to store |
| cfg_limit | input | 16 | Inclusive upper bound to store |
| addr | input | 16 | Processor address to decode |
| main_sel | output | 4 | One-hot main flash sector selects |
| boot_sel | output | 4 | One-hot boot flash sector selects |
| ram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O window select |
| pio_sel | output | 1 | Peripheral I/O window select |
| no_hit | output | 1 | No window matches the address |
| ovl_err | output | 1 | Same-tier overlap present |
| ovl_a | output | 4 | Lower index of the reported overlapping pair |
| ovl_b | output | 4 | Higher index of the reported overlapping pair |
| size_err | output | 1 | A flash window is oversized or inverted |
| size_win | output | 4 | Lowest index of a bad flash window |

## Verification
A single window write can change two things in the same cycle: which select wins at a fixed address, and the overlap report. The bench provokes this by writing a main or boot sector, or the I/O window, on top of a same-tier neighbour. After that edge it holds the address inside the shared range. In that one sample it checks that the lowest-index window wins and that ovl_err reports the expected index pair. It then removes the offending window and checks that the report moves to the next lowest pair, or clears. Random addresses are compared against a priority model written from the requirements, and this is repeated while several cross-tier overlaps are present.

// File: rtl/memsel_pkg.sv
// Package: shared sizes, the window record and tier classification for the
// chip-select decoder. Assumes a 16-bit address space and the fixed window
// index layout main sectors, boot sectors, SRAM terms, I/O, peripheral I/O.
package memsel_pkg;

    localparam int ADDR_W  = 16;
    localparam int N_MAIN  = 4;
    localparam int N_BOOT  = 4;
    localparam int N_RAM   = 2;
    localparam int N_TOP   = N_RAM + 2;
    localparam int N_WIN   = N_MAIN + N_BOOT + N_TOP;
    localparam int IDX_W   = $clog2(N_WIN + 1);
    localparam int BOOT_LO = N_MAIN;
    localparam int TOP_LO  = N_MAIN + N_BOOT;
    localparam int IO_IDX  = TOP_LO + N_RAM;
    localparam int PIO_IDX = IO_IDX + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  en;
        addr_t base;
        addr_t limit;
    } win_t;

    // Tier number of a window index: 0 top, 1 boot, 2 main.
    function automatic int tier_of(input int idx);
        if (idx < N_MAIN) return 2;
        if (idx < TOP_LO) return 1;
        return 0;
    endfunction

    // True when both indices are SRAM terms (allowed to overlap).
    function automatic bit both_ram(input int a, input int b);
        return (a >= TOP_LO) && (a < IO_IDX) && (b >= TOP_LO) && (b < IO_IDX);
    endfunction

endpackage

// File: rtl/memsel_cfg_regs.sv
// Window configuration registers. Holds one base/limit/enable record per
// window and loads it from the write port on the rising edge. Assumes a
// synchronous active-low reset; out-of-range indices are dropped.
module memsel_cfg_regs
    import memsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  addr_t                cfg_base,
    input  addr_t                cfg_limit,
    output win_t [N_WIN-1:0]     wins
);

    // Load the addressed window record, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wins <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_WIN; i++) begin
                if (cfg_idx == IDX_W'(i)) begin
                    wins[i].en    <= cfg_en;
                    wins[i].base  <= cfg_base;
                    wins[i].limit <= cfg_limit;
                end
            end
        end
    end

    assert_bad_index_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_idx >= IDX_W'(N_WIN))) |=> $stable(wins));

endmodule

// File: rtl/memsel_match.sv
// Window comparators. For every window, raises its hit bit when the window
// is enabled and the address lies within base..limit inclusive. Purely
// combinational; an inverted window (limit < base) never hits.
module memsel_match
    import memsel_pkg::*;
(
    input  addr_t                addr,
    input  win_t [N_WIN-1:0]     wins,
    output logic [N_WIN-1:0]     hit
);

    for (genvar i = 0; i < N_WIN; i++) begin : g_cmp
        // Inclusive range compare for window i.
        assign hit[i] = wins[i].en && (addr >= wins[i].base) && (addr <= wins[i].limit);
    end

endmodule

// File: rtl/memsel_prio.sv
// Priority resolver. Turns the raw hit vector into at most one select using
// the tier order top (SRAM/I/O/peripheral), boot, main, and lowest index
// inside a tier. Assumes the hit vector layout from memsel_pkg.
module memsel_prio
    import memsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_WIN-1:0]     hit,
    output logic [N_MAIN-1:0]    main_sel,
    output logic [N_BOOT-1:0]    boot_sel,
    output logic                 ram_sel,
    output logic                 io_sel,
    output logic                 pio_sel,
    output logic                 no_hit
);

    logic [N_MAIN-1:0] main_hit;
    logic [N_BOOT-1:0] boot_hit;
    logic [N_RAM-1:0]  ram_hit;
    logic              top_any;
    logic              boot_any;

    // Slice the hit vector by tier.
    assign main_hit = hit[N_MAIN-1:0];
    assign boot_hit = hit[TOP_LO-1:BOOT_LO];
    assign ram_hit  = hit[IO_IDX-1:TOP_LO];
    assign top_any  = (|ram_hit) | hit[IO_IDX] | hit[PIO_IDX];
    assign boot_any = |boot_hit;

    // Pick the winner: top tier first, then boot, then main, lowest index.
    always_comb begin
        ram_sel  = |ram_hit;
        io_sel   = hit[IO_IDX] & ~ram_sel;
        pio_sel  = hit[PIO_IDX] & ~ram_sel & ~hit[IO_IDX];
        boot_sel = top_any ? '0 : (boot_hit & (~boot_hit + 1'b1));
        main_sel = (top_any | boot_any) ? '0 : (main_hit & (~main_hit + 1'b1));
        no_hit   = ~|hit;
    end

    assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_sel, boot_sel, ram_sel, io_sel, pio_sel}));

    assert_nohit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        no_hit == ({main_sel, boot_sel, ram_sel, io_sel, pio_sel} == '0));

    assert_top_tier_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit[N_WIN-1:TOP_LO]) |-> (main_sel == '0 && boot_sel == '0));

    assert_boot_over_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit[TOP_LO-1:BOOT_LO]) |-> (main_sel == '0));

    assert_ram_terms_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit[IO_IDX-1:TOP_LO]) |-> ram_sel);

endmodule

// File: rtl/memsel_cfg_check.sv
// Configuration checker. Compares every pair of windows in the same tier for
// overlap and every flash window against its sector size, and reports the
// lowest offending pair and window. Combinational from the stored windows,
// so a write is reflected in the cycle after its clock edge.
module memsel_cfg_check
    import memsel_pkg::*;
#(
    parameter int MAIN_SECT = 16384,
    parameter int BOOT_SECT = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  win_t [N_WIN-1:0]     wins,
    output logic                 ovl_err,
    output logic [IDX_W-1:0]     ovl_a,
    output logic [IDX_W-1:0]     ovl_b,
    output logic                 size_err,
    output logic [IDX_W-1:0]     size_win
);

    localparam int SPAN_W = ADDR_W + 1;
    localparam int N_FL   = N_MAIN + N_BOOT;

    logic [N_WIN-1:0][N_WIN-1:0] pair_bad;
    logic [N_WIN-1:0]            too_big;
    logic [N_WIN-1:0]            well_formed;

    for (genvar i = 0; i < N_WIN; i++) begin : g_wf
        // A window takes part in overlap checks only when enabled and ordered.
        assign well_formed[i] = wins[i].en && (wins[i].limit >= wins[i].base);
    end

    for (genvar a = 0; a < N_WIN; a++) begin : g_row
        for (genvar b = 0; b < N_WIN; b++) begin : g_col
            if ((b > a) && (tier_of(a) == tier_of(b)) && !both_ram(a, b)) begin : g_chk
                // Same-tier pair: flag when the two ranges intersect.
                assign pair_bad[a][b] = well_formed[a] && well_formed[b] &&
                                        (wins[a].base <= wins[b].limit) &&
                                        (wins[b].base <= wins[a].limit);
            end else begin : g_none
                assign pair_bad[a][b] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_size
        if (i < N_FL) begin : g_flash
            localparam int SECT = (i < N_MAIN) ? MAIN_SECT : BOOT_SECT;
            logic [SPAN_W-1:0] span;
            // Span minus one; the top bit set means limit < base.
            assign span = {1'b0, wins[i].limit} - {1'b0, wins[i].base};
            assign too_big[i] = wins[i].en &&
                                (span[SPAN_W-1] || (span >= SPAN_W'(SECT)));
        end else begin : g_top
            assign too_big[i] = 1'b0;
        end
    end

    // Report the lowest overlapping pair (scan high to low, last write wins).
    always_comb begin
        ovl_err = 1'b0;
        ovl_a   = '0;
        ovl_b   = '0;
        for (int a = N_WIN - 1; a >= 0; a--) begin
            for (int b = N_WIN - 1; b >= 0; b--) begin
                if (pair_bad[a][b]) begin
                    ovl_err = 1'b1;
                    ovl_a   = IDX_W'(a);
                    ovl_b   = IDX_W'(b);
                end
            end
        end
    end

    // Report the lowest oversized or inverted flash window.
    always_comb begin
        size_err = 1'b0;
        size_win = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (too_big[i]) begin
                size_err = 1'b1;
                size_win = IDX_W'(i);
            end
        end
    end

    assert_pair_ordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_err |-> (ovl_a < ovl_b));

    assert_pair_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_err |-> (wins[ovl_a].en && wins[ovl_b].en));

    assert_ram_pair_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_err |-> !((ovl_a == IDX_W'(TOP_LO)) && (ovl_b == IDX_W'(TOP_LO + 1))));

    assert_size_flash_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> ((size_win < IDX_W'(N_FL)) && wins[size_win].en));

endmodule

// File: rtl/memsel_decoder.sv
// Top of the prioritized chip-select decoder. Stores the windows, compares
// the address against all of them, resolves the winner by tier and index,
// and reports same-tier overlaps and oversized flash windows. Selects are
// combinational from addr; configuration changes on the clock edge.
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int MAIN_SECT = 16384,
    parameter int BOOT_SECT = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [ADDR_W-1:0]    cfg_limit,
    input  logic [ADDR_W-1:0]    addr,
    output logic [N_MAIN-1:0]    main_sel,
    output logic [N_BOOT-1:0]    boot_sel,
    output logic                 ram_sel,
    output logic                 io_sel,
    output logic                 pio_sel,
    output logic                 no_hit,
    output logic                 ovl_err,
    output logic [IDX_W-1:0]     ovl_a,
    output logic [IDX_W-1:0]     ovl_b,
    output logic                 size_err,
    output logic [IDX_W-1:0]     size_win
);

    win_t [N_WIN-1:0] wins;
    logic [N_WIN-1:0] hit;

    memsel_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_en    (cfg_en),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .wins      (wins)
    );

    memsel_match u_match (
        .addr (addr),
        .wins (wins),
        .hit  (hit)
    );

    memsel_prio u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .main_sel (main_sel),
        .boot_sel (boot_sel),
        .ram_sel  (ram_sel),
        .io_sel   (io_sel),
        .pio_sel  (pio_sel),
        .no_hit   (no_hit)
    );

    memsel_cfg_check #(
        .MAIN_SECT (MAIN_SECT),
        .BOOT_SECT (BOOT_SECT)
    ) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .wins     (wins),
        .ovl_err  (ovl_err),
        .ovl_a    (ovl_a),
        .ovl_b    (ovl_b),
        .size_err (size_err),
        .size_win (size_win)
    );

    assert_disabled_no_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> no_hit);

endmodule

// File: tb/memsel_decoder_tb.sv
`timescale 1ns/1ps
module memsel_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_limit = '0;
    logic [15:0] addr = '0;
    logic [3:0]  main_sel;
    logic [3:0]  boot_sel;
    logic        ram_sel;
    logic        io_sel;
    logic        pio_sel;
    logic        no_hit;
    logic        ovl_err;
    logic [3:0]  ovl_a;
    logic [3:0]  ovl_b;
    logic        size_err;
    logic [3:0]  size_win;

    int checks = 0;
    int errors = 0;

    // Shadow of what the bench has written, for the reference model.
    bit          m_en   [12];
    logic [15:0] m_base [12];
    logic [15:0] m_lim  [12];

    // Select layout: {no_hit, pio, io, ram, boot[3:0], main[3:0]}.
    typedef struct packed {
        logic [15:0] a;
        logic [11:0] e;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{16'h8000, 12'h100}, '{16'h87FF, 12'h100},
        '{16'h8800, 12'h010}, '{16'h9FFF, 12'h010},
        '{16'hA000, 12'h001}, '{16'hBFFF, 12'h001},
        '{16'h7FFF, 12'h800}, '{16'hC000, 12'h800}
    };

    always #2.5 clk = ~clk;

    memsel_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .addr(addr), .main_sel(main_sel), .boot_sel(boot_sel),
        .ram_sel(ram_sel), .io_sel(io_sel), .pio_sel(pio_sel),
        .no_hit(no_hit), .ovl_err(ovl_err), .ovl_a(ovl_a), .ovl_b(ovl_b),
        .size_err(size_err), .size_win(size_win)
    );

    function automatic logic [11:0] sel_now();
        return {no_hit, pio_sel, io_sel, ram_sel, boot_sel, main_sel};
    endfunction

    function automatic logic [11:0] ref_sel(input logic [15:0] a);
        bit h [12];
        for (int i = 0; i < 12; i++) h[i] = m_en[i] && (a >= m_base[i]) && (a <= m_lim[i]);
        if (h[8] || h[9]) return 12'h100;
        if (h[10]) return 12'h200;
        if (h[11]) return 12'h400;
        for (int i = 4; i < 8; i++) if (h[i]) return 12'h010 << (i - 4);
        for (int i = 0; i < 4; i++) if (h[i]) return 12'h001 << i;
        return 12'h800;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic write_win(input int idx, input bit en, input logic [15:0] b, input logic [15:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 12) begin
            m_en[idx] = en; m_base[idx] = b; m_lim[idx] = l;
        end
    endtask

    task automatic probe(input logic [15:0] a);
        addr = a;
        #1;
    endtask

    task automatic check_ovl(input string req, input bit e, input int a, input int b);
        check(req, {31'd0, ovl_err}, {31'd0, e});
        if (e) check(req, {24'd0, ovl_a, ovl_b}, {24'd0, 4'(a), 4'(b)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) begin m_en[i] = 0; m_base[i] = '0; m_lim[i] = '0; end
        // R1: outputs during and after reset
        repeat (3) @(negedge clk);
        probe(16'h8000);
        check("R1 sel in reset", {20'd0, sel_now()}, 32'h800);
        rst_n = 1'b1;
        @(negedge clk);
        probe(16'h1234);
        check("R1 sel after reset", {20'd0, sel_now()}, 32'h800);
        check("R1 flags after reset", {30'd0, ovl_err, size_err}, 32'd0);

        // R9: stated example mapping, walked from the vector table (R3, R4)
        write_win(0, 1, 16'h8000, 16'hBFFF);
        write_win(4, 1, 16'h8000, 16'h9FFF);
        write_win(8, 1, 16'h8000, 16'h87FF);
        for (int v = 0; v < 8; v++) begin
            probe(VEC[v].a);
            check("R9 example map", {20'd0, sel_now()}, {20'd0, VEC[v].e});
        end
        check("R7 cross-tier overlap legal", {31'd0, ovl_err}, 32'd0);
        check("R8 example sizes legal", {31'd0, size_err}, 32'd0);

        // R5: second SRAM term, disjoint then overlapping the first
        write_win(9, 1, 16'h0000, 16'h00FF);
        probe(16'h0080);
        check("R5 ram term1", {20'd0, sel_now()}, 32'h100);
        write_win(9, 1, 16'h8400, 16'h8FFF);
        probe(16'h8C00);
        check("R5 ram term1 over boot", {20'd0, sel_now()}, 32'h100);
        check_ovl("R7 ram terms may overlap", 0, 0, 0);

        // R4/R6: a fuller map, then random addresses against the model
        write_win(10, 1, 16'hF000, 16'hF0FF);
        write_win(11, 1, 16'hF100, 16'hF1FF);
        write_win(1, 1, 16'hC000, 16'hFFFF);
        write_win(5, 1, 16'hE000, 16'hEFFF);
        write_win(2, 1, 16'h0000, 16'h3FFF);
        write_win(6, 1, 16'h1000, 16'h1FFF);
        probe(16'hF050); check("R4 io over main", {20'd0, sel_now()}, 32'h200);
        probe(16'hF150); check("R4 pio over main", {20'd0, sel_now()}, 32'h400);
        probe(16'hE800); check("R4 boot1 over main1", {20'd0, sel_now()}, 32'h020);
        probe(16'h1500); check("R4 boot2 over main2", {20'd0, sel_now()}, 32'h040);
        probe(16'h0500); check("R3 main2", {20'd0, sel_now()}, 32'h004);
        probe(16'h3FFF); check("R3 inclusive limit", {20'd0, sel_now()}, 32'h004);
        probe(16'h4000); check("R3 past limit", {20'd0, sel_now()}, 32'h800);
        check_ovl("R7 no same-tier overlap", 0, 0, 0);
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            probe(16'($urandom));
            check("R6 random vs model", {20'd0, sel_now()}, {20'd0, ref_sel(addr)});
        end

        // R11: address changes with no clock edge in between
        @(negedge clk);
        probe(16'hF050); check("R11 zero latency a", {20'd0, sel_now()}, 32'h200);
        probe(16'hE800); check("R11 zero latency b", {20'd0, sel_now()}, 32'h020);

        // R2: out-of-range index is ignored
        write_win(12, 1, 16'h4000, 16'h4FFF);
        probe(16'h4800);
        check("R2 index 12 ignored", {20'd0, sel_now()}, 32'h800);
        write_win(15, 1, 16'h4000, 16'h4FFF);
        probe(16'h4800);
        check("R2 index 15 ignored", {20'd0, sel_now()}, 32'h800);

        // R3: disabled window never matches
        write_win(5, 0, 16'hE000, 16'hEFFF);
        probe(16'hE800);
        check("R3 disabled boot1", {20'd0, sel_now()}, 32'h002);

        // R10/R7: same-tier overlaps, winner and report in the same cycle
        write_win(3, 1, 16'hC000, 16'hC0FF);
        probe(16'hC050);
        check("R10 main lowest wins", {20'd0, sel_now()}, 32'h002);
        check_ovl("R7 main pair", 1, 1, 3);
        write_win(7, 1, 16'h1800, 16'h18FF);
        probe(16'h1850);
        check("R10 boot lowest wins", {20'd0, sel_now()}, 32'h040);
        check_ovl("R7 lowest pair kept", 1, 1, 3);
        write_win(3, 0, 16'hC000, 16'hC0FF);
        check_ovl("R7 next pair", 1, 6, 7);
        write_win(7, 0, 16'h1800, 16'h18FF);
        check_ovl("R7 cleared", 0, 0, 0);
        write_win(10, 1, 16'hF000, 16'hF1FF);
        probe(16'hF150);
        check("R10 io over pio", {20'd0, sel_now()}, 32'h200);
        check_ovl("R7 top pair", 1, 10, 11);
        write_win(10, 1, 16'hF000, 16'hF0FF);
        check_ovl("R7 top cleared", 0, 0, 0);

        // R8: sector size limits
        write_win(2, 1, 16'h0000, 16'h4000);
        check("R8 main oversize", {27'd0, size_err, size_win}, {27'd0, 1'b1, 4'd2});
        write_win(2, 1, 16'h0000, 16'h3FFF);
        write_win(5, 1, 16'hE000, 16'hFFFF);
        check("R8 boot exact size", {31'd0, size_err}, 32'd0);
        write_win(5, 1, 16'hE000, 16'hDFFF);
        check("R8 boot inverted", {27'd0, size_err, size_win}, {27'd0, 1'b1, 4'd5});
        write_win(5, 0, 16'hE000, 16'hDFFF);
        check("R8 cleared", {31'd0, size_err}, 32'd0);

        // R1: reset again clears all windows
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe(16'h8000);
        check("R1 reset clears windows", {20'd0, sel_now()}, 32'h800);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule